// File: doc/BRIEF.md
# Full/Empty Tagged Synchronizing Memory

This block is a word-addressed store in which each data word is paired with a single presence bit. The bit reads as "full" when the word holds a value that has been produced and not yet consumed, and as "empty" otherwise. Producer and consumer threads use synchronizing operations on this store. Each such operation tests the presence bit and updates it in the same step as the data access. When the test fails, the block raises a trap flag in the response, and a trap handler elsewhere decides what to do next.

The presence bits are not kept beside each data word. They are packed into one small tag field for each group of four consecutive words, so a single tag entry covers one line. Requests arrive one per cycle on a request port, which carries an opcode, a word address and write data. Exactly one cycle later a response carries the data word, the trap flag and the presence state that the word holds after the operation. Plain loads and stores are also accepted. They move data and leave the presence bit untouched.

Top module: `fe_sync_mem`

## Requirements
- R1: After reset every presence bit is empty and every data word is zero, and no response is presented until a request is accepted.
- R2: A request accepted with `req_valid` high on a clock edge produces a response with `rsp_valid` high for exactly the following cycle. `rsp_rdata` carries the value the addressed word held before that request.
- R3: Plain load (opcode 0) and plain store (opcode 1) never trap and never change the presence bit. `rsp_full` reports the bit as it stands. A plain store writes `req_wdata` to the word.
- R4: Opcode 2 (load, trap if empty) never changes data or the bit. It traps exactly when the word is empty.
- R5: Opcode 3 (load and consume) traps when the word is empty. Otherwise it clears the bit to empty, and `rsp_full` then reads 0.
- R6: Opcode 4 (store and fill) always writes `req_wdata`, sets the bit full and never traps.
- R7: Opcode 5 (store and fill, trap if full) traps when the word is already full. Otherwise it writes `req_wdata` and sets the bit full.
- R8: A request that traps leaves both the data word and its presence bit unchanged.
- R9: Each operation completes its test and update in one cycle. A request in the very next cycle to the same word observes the updated data and bit.
- R10: The bits of the four words that share a line (same address except bits [1:0]) are independent. Updating one word's bit never alters another's.
- R11: The unused opcodes 6 and 7 behave as a plain load. They write nothing, change no bit and never trap.
- R12: While `rsp_valid` is low, `rsp_rdata`, `rsp_trap` and `rsp_full` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (0..7, see requirements) |
| req_addr | input | ADDR_W (6) | Word address |
| req_wdata | input | DATA_W (32) | Data for store operations |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_rdata | output | DATA_W (32) | Word value before the operation |
| rsp_trap | output | 1 | Tested condition failed; nothing was modified |
| rsp_full | output | 1 | Presence state of the word after the operation |

## Verification
Internal state of this block appears at the ports only through a later request to the same word. A wrong presence bit therefore shows up on the next request to that word: a spurious or missing trap, or a wrong `rsp_full`, one cycle after that request. A data word corrupted by a trapped store shows up only when that word is next read. For this reason the stimulus revisits the same word back to back, and it probes the neighbouring words of the same line right after each update.

// File: rtl/fe_sync_mem.sv
module fe_sync_mem #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter int LINE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_trap,
  output logic              rsp_full
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int OFS_W = $clog2(LINE_W);
  localparam int LINES = DEPTH / LINE_W;
  localparam int LIX_W = ADDR_W - OFS_W;

  localparam logic [2:0] OP_LD   = 3'd0;
  localparam logic [2:0] OP_ST   = 3'd1;
  localparam logic [2:0] OP_LDT  = 3'd2;
  localparam logic [2:0] OP_LDC  = 3'd3;
  localparam logic [2:0] OP_STF  = 3'd4;
  localparam logic [2:0] OP_STFT = 3'd5;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [LINE_W-1:0] tag [LINES];

  wire [LIX_W-1:0]  line_ix = req_addr[ADDR_W-1:OFS_W];
  wire [OFS_W-1:0]  word_ix = req_addr[OFS_W-1:0];
  wire              cur_full = tag[line_ix][word_ix];
  wire [DATA_W-1:0] cur_data = mem[req_addr];

  logic trap, wr_data, nxt_full;

  always_comb begin
    trap     = 1'b0;
    wr_data  = 1'b0;
    nxt_full = cur_full;
    unique case (req_op)
      OP_ST:   wr_data = 1'b1;
      OP_LDT:  trap = ~cur_full;
      OP_LDC:  begin trap = ~cur_full; nxt_full = 1'b0; end
      OP_STF:  begin wr_data = 1'b1; nxt_full = 1'b1; end
      OP_STFT: begin trap = cur_full; wr_data = ~cur_full; nxt_full = 1'b1; end
      default: ;
    endcase
    if (trap) nxt_full = cur_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) tag[i] <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (req_valid) begin
      tag[line_ix][word_ix] <= nxt_full;
      if (wr_data) mem[req_addr] <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_trap  <= 1'b0;
      rsp_full  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= req_valid ? cur_data : '0;
      rsp_trap  <= req_valid & trap;
      rsp_full  <= req_valid & nxt_full;
    end
  end
endmodule

// File: rtl/fe_sync_mem_chk.sv
module fe_sync_mem_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_op,
  input logic       rsp_valid,
  input logic       rsp_trap,
  input logic       rsp_full
);
  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_trap && !rsp_full));
  // R3
  plain_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op == 3'd0 || req_op == 3'd1 || req_op[2:1] == 2'b11)) |=> !rsp_trap);
  // R4
  ldt_trap_iff_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd2) |=> (rsp_trap != rsp_full));
  // R5
  consume_ends_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd3) |=> !rsp_full);
  // R6
  fill_always_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd4) |=> (rsp_full && !rsp_trap));
  // R7
  fillt_ends_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd5) |=> rsp_full);
endmodule

bind fe_sync_mem fe_sync_mem_chk chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .rsp_valid(rsp_valid), .rsp_trap(rsp_trap), .rsp_full(rsp_full)
);

// File: tb/fe_sync_mem_test.sv
module fe_sync_mem_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_trap, rsp_full;
  logic [31:0] rsp_rdata;

  int applied = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fe_sync_mem uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_trap(rsp_trap), .rsp_full(rsp_full)
  );

  localparam int NV = 22;
  // {req(4), op(3), addr(6), wdata(32), exp_rdata(32), exp_trap, exp_full}
  localparam logic [78:0] VEC [NV] = '{
    {4'd3,  3'd0, 6'd5,  32'h0,        32'h0,        1'b0, 1'b0}, // R3 R1
    {4'd4,  3'd2, 6'd5,  32'h0,        32'h0,        1'b1, 1'b0}, // R4
    {4'd5,  3'd3, 6'd5,  32'h0,        32'h0,        1'b1, 1'b0}, // R5
    {4'd7,  3'd5, 6'd5,  32'h0000_00A1, 32'h0,        1'b0, 1'b1}, // R7
    {4'd8,  3'd5, 6'd5,  32'h0000_00B2, 32'h0000_00A1, 1'b1, 1'b1}, // R8 R7
    {4'd8,  3'd0, 6'd5,  32'h0,        32'h0000_00A1, 1'b0, 1'b1}, // R8
    {4'd10, 3'd0, 6'd4,  32'h0,        32'h0,        1'b0, 1'b0}, // R10
    {4'd10, 3'd0, 6'd6,  32'h0,        32'h0,        1'b0, 1'b0}, // R10
    {4'd4,  3'd2, 6'd5,  32'h0,        32'h0000_00A1, 1'b0, 1'b1}, // R4
    {4'd5,  3'd3, 6'd5,  32'h0,        32'h0000_00A1, 1'b0, 1'b0}, // R5
    {4'd9,  3'd3, 6'd5,  32'h0,        32'h0000_00A1, 1'b1, 1'b0}, // R9 R5
    {4'd3,  3'd1, 6'd5,  32'h0000_00C3, 32'h0000_00A1, 1'b0, 1'b0}, // R3
    {4'd6,  3'd4, 6'd5,  32'h0000_00D4, 32'h0000_00C3, 1'b0, 1'b1}, // R6
    {4'd6,  3'd4, 6'd5,  32'h0000_00E5, 32'h0000_00D4, 1'b0, 1'b1}, // R6
    {4'd3,  3'd1, 6'd5,  32'h0000_00F6, 32'h0000_00E5, 1'b0, 1'b1}, // R3
    {4'd11, 3'd6, 6'd5,  32'h0000_0999, 32'h0000_00F6, 1'b0, 1'b1}, // R11
    {4'd11, 3'd7, 6'd5,  32'h0000_0123, 32'h0000_00F6, 1'b0, 1'b1}, // R11
    {4'd11, 3'd0, 6'd5,  32'h0,        32'h0000_00F6, 1'b0, 1'b1}, // R11
    {4'd6,  3'd4, 6'd63, 32'h0000_0077, 32'h0,        1'b0, 1'b1}, // R6
    {4'd10, 3'd0, 6'd60, 32'h0,        32'h0,        1'b0, 1'b0}, // R10
    {4'd10, 3'd2, 6'd62, 32'h0,        32'h0,        1'b1, 1'b0}, // R10
    {4'd9,  3'd0, 6'd63, 32'h0,        32'h0000_0077, 1'b0, 1'b1}  // R9
  };

  task automatic check(input int req, input logic v, input logic [31:0] rd,
                       input logic tr, input logic fu);
    applied++;
    if (rsp_valid !== v || rsp_rdata !== rd || rsp_trap !== tr || rsp_full !== fu) begin
      bad++;
      $display("FAIL R%0d: got valid=%b rdata=%h trap=%b full=%b, expected valid=%b rdata=%h trap=%b full=%b",
               req, rsp_valid, rsp_rdata, rsp_trap, rsp_full, v, rd, tr, fu);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [5:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, 1'b0, 32'h0, 1'b0, 1'b0); // R1 reset outputs
    rst_n = 1'b1;
    @(negedge clk);
    check(12, 1'b0, 32'h0, 1'b0, 1'b0); // R12 idle

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][74:72], VEC[i][71:66], VEC[i][65:34]);
      @(negedge clk);
      check(int'(VEC[i][78:75]), 1'b1, VEC[i][33:2], VEC[i][1], VEC[i][0]);
    end
    req_valid = 1'b0;
    @(negedge clk);
    check(2, 1'b0, 32'h0, 1'b0, 1'b0); // R2 single-cycle response, R12

    // R2: isolated request with idle gap
    drive(3'd0, 6'd5, 32'h0);
    @(negedge clk);
    req_valid = 1'b0;
    check(2, 1'b1, 32'h0000_00F6, 1'b0, 1'b1);
    @(negedge clk);
    check(2, 1'b0, 32'h0, 1'b0, 1'b0);

    // R9: fill then consume back to back on a fresh word
    drive(3'd4, 6'd17, 32'hCAFE_0001);
    @(negedge clk);
    check(9, 1'b1, 32'h0, 1'b0, 1'b1);
    drive(3'd3, 6'd17, 32'h0);
    @(negedge clk);
    check(9, 1'b1, 32'hCAFE_0001, 1'b0, 1'b0);
    drive(3'd5, 6'd17, 32'hCAFE_0002);
    @(negedge clk);
    check(9, 1'b1, 32'hCAFE_0001, 1'b0, 1'b1);
    req_valid = 1'b0;
    @(negedge clk);

    // R1: reset mid-run clears bits and data
    rst_n = 1'b0;
    @(negedge clk);
    check(1, 1'b0, 32'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    drive(3'd0, 6'd5, 32'h0);
    @(negedge clk);
    check(1, 1'b1, 32'h0, 1'b0, 1'b0);
    drive(3'd2, 6'd63, 32'h0);
    @(negedge clk);
    check(1, 1'b1, 32'h0, 1'b1, 1'b0);
    drive(3'd0, 6'd17, 32'h0);
    @(negedge clk);
    check(1, 1'b1, 32'h0, 1'b0, 1'b0);
    req_valid = 1'b0;
    @(negedge clk);
    finish_run();
  end
endmodule